// File: doc/BRIEF.md
# Security Fault Interrupt and Response Unit

This block gathers access-check faults from up to four address filter units and turns them into software-visible flags, one level-sensitive interrupt line and a per-access bus response choice. Every cycle, each filter may present an access strobe, a permission-failure qualifier and the vector of protection regions the access hit. The block works out whether that access is an overlap error and whether it faults. Per filter, it keeps a sticky status flag, an overrun flag and an overlap flag.

Software uses a three-word register port. A two-bit action word selects whether faults raise the interrupt line and whether a faulting access gets a DECERR or an OKAY response. A read-only status word shows every flag. A write-only clear word drops all three flags of any filter whose bit is written as 1. The flags record every fault whatever the action setting, so a polling driver sees faults with the interrupt line masked.

Top module: `sfu_fault_irq`

## Requirements
- R1: After reset the action word is 0, all flags are 0, `irq_o` is low and every `resp_decerr_o` bit is 0.
- R2: A write to address 0 stores write-data bits 1:0 as the action word. Reading address 0 returns it in bits 1:0 with zeros above.
- R3: A faulting access on filter n sets status flag n (status word bit n) on the next clock edge, whatever the action word holds.
- R4: A fault on filter n while its status flag is already set (and not cleared in the same cycle) sets overrun flag n (status word bit 8+n). A first fault does not.
- R5: An access with the strobe high whose region-hit vector has two or more bits set among regions 1 and up is an overlap error. It sets overlap flag n (status word bit 16+n) and status flag n. Hits on region 0 plus one other region are not an overlap error.
- R6: Writing the clear word at address 2 with bit n set clears the status, overrun and overlap flags of filter n together. Other filters keep their flags.
- R7: When a clear of filter n and a new fault on filter n fall in the same cycle, the new fault wins. Status flag n ends set, overrun flag n ends clear, and overlap flag n ends equal to whether the new fault was an overlap error.
- R8: `irq_o` is high exactly while action bit 1 is 1 and at least one status flag is set. It stays high until every set status flag is cleared.
- R9: `resp_decerr_o[n]` is 1 in the same cycle as a faulting access on filter n when action bit 0 is 1, and is 0 otherwise (OKAY).
- R10: The status word at address 1 has status in bits 3:0, overrun in 11:8 and overlap in 19:16, with all other bits 0. Writes to address 1 have no effect. Reads of addresses 2 and 3 return 0.
- R11: An access with the strobe high, no permission failure and at most one region hit among regions 1 and up changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | NUM_FILT | Per-filter access strobe, one cycle per checked access |
| perm_fail_i | input | NUM_FILT | Per-filter permission-failure qualifier, valid with the strobe |
| region_hit_i | input | NUM_FILT*NUM_REG | Per-filter region-hit vectors; filter n uses bits n*NUM_REG upward, bit 0 of each is region 0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address: 0 action, 1 status, 2 clear |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |
| resp_decerr_o | output | NUM_FILT | Per-filter response select for the current access: 1 DECERR, 0 OKAY |

## Verification
Two functions meet in one cycle: a software clear of a filter's flags and a fresh fault on that same filter. The bench provokes this first after two faults have set both status and overrun, writing the clear word while the filter raises a permission failure. It provokes it a second time with an overlap-only access. It judges the result by reading the status word afterwards: status set, overrun gone, overlap following the new access. A reference model also compares the interrupt, the response bits and the read data on every clock, so the interrupt's behaviour across that cycle is checked too.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int SFU_AW = 2;
  localparam int SFU_DW = 32;
  localparam int SFU_FLD_W = 8;

  localparam logic [SFU_AW-1:0] SFU_A_ACTION = 2'd0;
  localparam logic [SFU_AW-1:0] SFU_A_STATUS = 2'd1;
  localparam logic [SFU_AW-1:0] SFU_A_CLEAR  = 2'd2;

  // Status word: status flags from bit 0, overrun from bit 8, overlap from bit 16.
  function automatic logic [SFU_DW-1:0] sfu_pack_status(
    input logic [SFU_FLD_W-1:0] st,
    input logic [SFU_FLD_W-1:0] ov,
    input logic [SFU_FLD_W-1:0] ol
  );
    return {8'h00, ol, ov, st};
  endfunction
endpackage

// File: rtl/sfu_overlap_chk.sv
module sfu_overlap_chk #(
  parameter int NUM_REG = 9
) (
  input  logic               valid_i,
  input  logic               perm_fail_i,
  input  logic [NUM_REG-1:0] hits_i,
  output logic               ovl_err_o,
  output logic               fault_o
);
  localparam int CNT_W = $clog2(NUM_REG + 1);

  // Region 0 is the background region and never counts toward an overlap.
  function automatic logic [CNT_W-1:0] count_upper(input logic [NUM_REG-1:0] h);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int r = 1; r < NUM_REG; r++) begin
      c = c + CNT_W'(h[r]);
    end
    return c;
  endfunction

  logic [CNT_W-1:0] upper_hits;
  assign upper_hits = count_upper(hits_i);
  assign ovl_err_o  = valid_i && (upper_hits >= CNT_W'(2));
  assign fault_o    = valid_i && (perm_fail_i || ovl_err_o);
endmodule

// File: rtl/sfu_flag_cell.sv
module sfu_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic ovl_err_i,
  input  logic clr_i,
  output logic stat_o,
  output logic ovr_o,
  output logic ovl_o
);
  logic stat_q, ovr_q, ovl_q;
  logic held;

  // A flag survives the cycle only if no clear targets it.
  assign held = stat_q && !clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      ovr_q  <= 1'b0;
      ovl_q  <= 1'b0;
    end else begin
      stat_q <= fault_i || held;
      ovr_q  <= (fault_i && held) || (ovr_q && !clr_i);
      ovl_q  <= ovl_err_i || (ovl_q && !clr_i);
    end
  end

  assign stat_o = stat_q;
  assign ovr_o  = ovr_q;
  assign ovl_o  = ovl_q;
endmodule

// File: rtl/sfu_regif.sv
module sfu_regif
  import sfu_pkg::*;
#(
  parameter int NUM_FILT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [SFU_AW-1:0]    addr_i,
  input  logic [SFU_DW-1:0]    wdata_i,
  input  logic [NUM_FILT-1:0]  stat_i,
  input  logic [NUM_FILT-1:0]  ovr_i,
  input  logic [NUM_FILT-1:0]  ovl_i,
  output logic [1:0]           act_o,
  output logic [NUM_FILT-1:0]  clr_o,
  output logic [SFU_DW-1:0]    rdata_o
);
  logic [1:0] act_q;
  logic [SFU_FLD_W-1:0] st8, ov8, ol8;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[SFU_DW-1:SFU_FLD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 2'b00;
    end else if (wr_i && addr_i == SFU_A_ACTION) begin
      act_q <= wdata_i[1:0];
    end
  end

  assign clr_o = (wr_i && addr_i == SFU_A_CLEAR) ? wdata_i[NUM_FILT-1:0] : '0;

  always_comb begin
    st8 = '0;
    ov8 = '0;
    ol8 = '0;
    st8[NUM_FILT-1:0] = stat_i;
    ov8[NUM_FILT-1:0] = ovr_i;
    ol8[NUM_FILT-1:0] = ovl_i;
  end

  always_comb begin
    case (addr_i)
      SFU_A_ACTION: rdata_o = {{(SFU_DW-2){1'b0}}, act_q};
      SFU_A_STATUS: rdata_o = sfu_pack_status(st8, ov8, ol8);
      default:      rdata_o = '0;
    endcase
  end

  assign act_o = act_q;
endmodule

// File: rtl/sfu_fault_irq.sv
module sfu_fault_irq
  import sfu_pkg::*;
#(
  parameter int NUM_FILT = 4,   // at most 8: the status word has 8-bit fields
  parameter int NUM_REG  = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_FILT-1:0]         acc_valid_i,
  input  logic [NUM_FILT-1:0]         perm_fail_i,
  input  logic [NUM_FILT*NUM_REG-1:0] region_hit_i,
  input  logic                        reg_wr_i,
  input  logic [SFU_AW-1:0]           reg_addr_i,
  input  logic [SFU_DW-1:0]           reg_wdata_i,
  output logic [SFU_DW-1:0]           reg_rdata_o,
  output logic                        irq_o,
  output logic [NUM_FILT-1:0]         resp_decerr_o
);
  // Named internal events, visible to the bound checker.
  logic [NUM_FILT-1:0] fault_w;
  logic [NUM_FILT-1:0] ovl_err_w;
  logic [NUM_FILT-1:0] clr_w;
  logic [NUM_FILT-1:0] stat_w;
  logic [NUM_FILT-1:0] ovr_w;
  logic [NUM_FILT-1:0] ovl_w;
  logic [1:0]          act_w;

  for (genvar n = 0; n < NUM_FILT; n++) begin : g_filt
    sfu_overlap_chk #(.NUM_REG(NUM_REG)) u_ovl (
      .valid_i     (acc_valid_i[n]),
      .perm_fail_i (perm_fail_i[n]),
      .hits_i      (region_hit_i[n*NUM_REG +: NUM_REG]),
      .ovl_err_o   (ovl_err_w[n]),
      .fault_o     (fault_w[n])
    );

    sfu_flag_cell u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_i   (fault_w[n]),
      .ovl_err_i (ovl_err_w[n]),
      .clr_i     (clr_w[n]),
      .stat_o    (stat_w[n]),
      .ovr_o     (ovr_w[n]),
      .ovl_o     (ovl_w[n])
    );
  end

  sfu_regif #(.NUM_FILT(NUM_FILT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat_w),
    .ovr_i   (ovr_w),
    .ovl_i   (ovl_w),
    .act_o   (act_w),
    .clr_o   (clr_w),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o         = act_w[1] && (|stat_w);
  assign resp_decerr_o = fault_w & {NUM_FILT{act_w[0]}};
endmodule

// File: rtl/sfu_fault_irq_chk.sv
module sfu_fault_irq_chk #(
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] fault,
  input logic [NF-1:0] ovl_err,
  input logic [NF-1:0] clr,
  input logic [NF-1:0] stat,
  input logic [NF-1:0] ovr,
  input logic [NF-1:0] ovl,
  input logic [1:0]    act,
  input logic          irq,
  input logic [NF-1:0] resp,
  input logic [1:0]    reg_addr,
  input logic [31:0]   rdata
);
  a_r3_fault_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != '0) |=> ((stat & $past(fault)) == $past(fault)));

  a_r4_overrun_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr & ~stat) == '0));

  a_r5_overlap_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovl & ~stat) == '0));

  a_r5_overlap_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovl_err & ~fault) == '0));

  a_r6_clear_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~fault) != '0) |=> (((stat | ovr | ovl) & $past(clr & ~fault)) == '0));

  a_r7_fault_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & fault) != '0) |=> (((stat & $past(clr & fault)) == $past(clr & fault))
                               && ((ovr & $past(clr & fault)) == '0)));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !act[1] |-> !irq);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));

  a_r9_resp_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((resp & ~fault) == '0));

  a_r9_resp_needs_action: assert property (@(posedge clk) disable iff (!rst_n)
    (resp != '0) |-> act[0]);

  a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (rdata == 32'h0));
endmodule

bind sfu_fault_irq sfu_fault_irq_chk #(.NF(NUM_FILT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fault    (fault_w),
  .ovl_err  (ovl_err_w),
  .clr      (clr_w),
  .stat     (stat_w),
  .ovr      (ovr_w),
  .ovl      (ovl_w),
  .act      (act_w),
  .irq      (irq_o),
  .resp     (resp_decerr_o),
  .reg_addr (reg_addr_i),
  .rdata    (reg_rdata_o)
);

// File: tb/sfu_fault_irq_test.sv
`timescale 1ns/1ps
module sfu_fault_irq_test;
  localparam int NF = 4;
  localparam int NR = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] b_valid = '0;
  logic [NF-1:0] b_fail = '0;
  logic [NR-1:0] b_hit [NF];
  logic b_wr = 1'b0;
  logic [1:0] b_addr = 2'd0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [NF-1:0] resp;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // Reference model state
  int m_st [NF];
  int m_ov [NF];
  int m_ol [NF];
  int m_act = 0;

  always #5 clk = ~clk;

  sfu_fault_irq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid_i   (b_valid),
    .perm_fail_i   (b_fail),
    .region_hit_i  ({b_hit[3], b_hit[2], b_hit[1], b_hit[0]}),
    .reg_wr_i      (b_wr),
    .reg_addr_i    (b_addr),
    .reg_wdata_i   (b_wdata),
    .reg_rdata_o   (rdata),
    .irq_o         (irq),
    .resp_decerr_o (resp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_ovl(input int n);
    int c = 0;
    for (int r = 1; r < NR; r++) if (b_hit[n][r]) c++;
    return b_valid[n] && c > 1;
  endfunction

  function automatic bit m_fault(input int n);
    return b_valid[n] && (b_fail[n] || m_ovl(n));
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] w = 0;
    for (int n = 0; n < NF; n++) begin
      if (m_st[n] != 0) w = w + (32'd1 << n);
      if (m_ov[n] != 0) w = w + (32'd1 << (n + 8));
      if (m_ol[n] != 0) w = w + (32'd1 << (n + 16));
    end
    return w;
  endfunction

  task automatic idle();
    b_valid = '0; b_fail = '0; b_wr = 1'b0; b_wdata = '0;
    for (int n = 0; n < NF; n++) b_hit[n] = '0;
  endtask

  // One clock: compare outputs against the model, advance the model at the edge.
  task automatic tick();
    logic [NF-1:0] er;
    logic [31:0] erd;
    bit any;
    #1;
    er = '0; any = 0;
    for (int n = 0; n < NF; n++) begin
      er[n] = m_fault(n) && (m_act % 2 == 1);
      if (m_st[n] != 0) any = 1;
    end
    chk("R9 resp per cycle", 32'(resp), 32'(er));
    chk("R8 irq per cycle", 32'(irq), 32'((m_act >= 2) && any));
    if (b_addr == 2'd0) erd = 32'(m_act);
    else if (b_addr == 2'd1) erd = m_status();
    else erd = 32'h0;
    chk("R10 rdata per cycle", rdata, erd);
    @(posedge clk);
    for (int n = 0; n < NF; n++) begin
      bit f = m_fault(n);
      bit ol = m_ovl(n);
      bit cl = b_wr && b_addr == 2'd2 && b_wdata[n];
      bit kept = (m_st[n] != 0) && !cl;
      if (cl) begin m_st[n] = 0; m_ov[n] = 0; m_ol[n] = 0; end
      if (f) begin
        if (kept) m_ov[n] = 1;
        m_st[n] = 1;
        if (ol) m_ol[n] = 1;
      end
    end
    if (b_wr && b_addr == 2'd0) m_act = int'(b_wdata[1:0]);
    @(negedge clk);
    idle();
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string tag);
    b_addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    tick();
  endtask

  task automatic fault(input int n, input bit pf, input logic [NR-1:0] h);
    b_valid[n] = 1'b1; b_fail[n] = pf; b_hit[n] = h;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NF; n++) begin m_st[n] = 0; m_ov[n] = 0; m_ol[n] = 0; end
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd1, 32'h0, "R1 status after reset");
    peek(2'd0, 32'h0, "R1 action after reset");
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 resp after reset", 32'(resp), 32'h0);

    // R2 action register
    wr(2'd0, 32'hFFFF_FFFC);
    peek(2'd0, 32'h0, "R2 upper bits dropped");
    wr(2'd0, 32'h3);
    peek(2'd0, 32'h3, "R2 action readback");
    wr(2'd0, 32'h0);

    // R3 status with interrupt masked
    fault(0, 1'b1, 9'h002);
    peek(2'd1, 32'h1, "R3 status sets while masked");
    chk("R8 irq masked", 32'(irq), 32'h0);

    // R4 overrun
    fault(0, 1'b1, 9'h002);
    peek(2'd1, 32'h101, "R4 second fault sets overrun");
    fault(2, 1'b1, 9'h000);
    peek(2'd1, 32'h105, "R4 first fault no overrun");

    // R6 selective clear
    wr(2'd2, 32'h1);
    peek(2'd1, 32'h4, "R6 clear filter0 only");

    // R5 overlap and region-0 exemption
    fault(1, 1'b0, 9'h009);
    peek(2'd1, 32'h4, "R5 region0 exempt");
    fault(1, 1'b0, 9'h028);
    peek(2'd1, 32'h20006, "R5 overlap flags");

    // R11 clean access
    fault(3, 1'b0, 9'h010);
    peek(2'd1, 32'h20006, "R11 clean access no change");

    // R8 interrupt level
    wr(2'd0, 32'h2);
    chk("R8 irq enabled with flags", 32'(irq), 32'h1);
    wr(2'd2, 32'h2);
    peek(2'd1, 32'h4, "R6 clear filter1 all flags");
    chk("R8 irq held by remaining flag", 32'(irq), 32'h1);
    wr(2'd2, 32'h4);
    chk("R8 irq drops when all clear", 32'(irq), 32'h0);

    // R7 clear and fault in same cycle
    fault(3, 1'b1, 9'h000);
    fault(3, 1'b1, 9'h000);
    peek(2'd1, 32'h808, "R7 setup status and overrun");
    b_wr = 1'b1; b_addr = 2'd2; b_wdata = 32'h8;
    b_valid[3] = 1'b1; b_fail[3] = 1'b1;
    tick();
    peek(2'd1, 32'h8, "R7 fault wins, overrun gone");
    chk("R7 irq stays high", 32'(irq), 32'h1);
    b_wr = 1'b1; b_addr = 2'd2; b_wdata = 32'h8;
    b_valid[3] = 1'b1; b_hit[3] = 9'h006;
    tick();
    peek(2'd1, 32'h80008, "R7 overlap fault wins over clear");
    wr(2'd2, 32'h8);
    peek(2'd1, 32'h0, "R6 clear filter3");

    // R9 response selection
    wr(2'd0, 32'h1);
    b_valid[2] = 1'b1; b_fail[2] = 1'b1;
    #1 chk("R9 decerr on failure", 32'(resp), 32'h4);
    tick();
    b_valid[1] = 1'b1; b_hit[1] = 9'h006;
    #1 chk("R9 decerr on overlap", 32'(resp), 32'h2);
    tick();
    wr(2'd0, 32'h0);
    b_valid[2] = 1'b1; b_fail[2] = 1'b1;
    #1 chk("R9 okay when action bit0 clear", 32'(resp), 32'h0);
    tick();
    peek(2'd1, 32'h20406, "R4 overrun on filter2");

    // R10 status write ignored, clear reads zero
    wr(2'd1, 32'hFFFF_FFFF);
    peek(2'd1, 32'h20406, "R10 status write ignored");
    peek(2'd2, 32'h0, "R10 clear reads zero");
    peek(2'd3, 32'h0, "R10 unused reads zero");
    wr(2'd2, 32'hF);
    peek(2'd1, 32'h0, "R6 clear all filters");

    repeat (2) tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule